// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the word address for one port of a synchronous memory. At each rising clock edge it picks the address for the access that the edge starts. There are four choices: an external address presented on the port, zero, the last address plus one, or the last address unchanged. The chosen value is registered. It drives the memory array for that access and is also the base for the next edge.

A host can run a burst by loading a start address once and then pulsing the count enable, with no further address traffic. A clear forces address zero on the same edge, so an access can start at zero with no idle cycle. The generator has no chip-select or byte-lane inputs. It advances or loads whatever the surrounding port is doing.

The stored address is undefined after power-up. It becomes defined at the first edge that loads or clears it.

Top module: `burst_addr_gen`

## Requirements
- R1: With the clear input high and the strobe input low at an edge, the output after that edge equals the external address sampled at that edge.
- R2: With clear high, strobe high and count enable low at an edge, the output after that edge is the previous output plus one.
- R3: With clear, strobe and count enable all high at an edge, the output keeps its previous value, and the external address has no effect.
- R4: With clear low at an edge, the output after that edge is zero, whatever the strobe, count enable and external address are.
- R5: A clear costs no idle cycle: an increment on the edge right after a clear gives address one.
- R6: Incrementing from the all-ones address gives zero, and counting then continues from zero.
- R7: When strobe and count enable are both low at an edge, the load wins: the output is the external address, not an incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| extAddr | input | ADDR_W (15) | Address presented by the host, taken when the strobe is low |
| adsN | input | 1 | Active-low load strobe |
| cntEnN | input | 1 | Active-low count enable |
| cntRstN | input | 1 | Active-low clear to address zero, highest priority |
| intAddr | output | ADDR_W (15) | Registered address for the current access |

## Verification
The assertions assume that the stored address is meaningful only once a load or a clear has occurred. The checker keeps its own flag for this and disables every property until the flag is set. The stimulus starts with a clear so that every later output is defined. Only two's-complement wrap is assumed for the increment. The stimulus covers that case by loading an address just below the all-ones value and counting through the top of the range.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // One-hot-or-none strobe set passed from control to datapath.
  typedef struct packed {
    logic clear;  // force zero
    logic load;   // take external address
    logic step;   // add one to held address
  } addr_ctl_t;

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic      adsN,
  input  logic      cntEnN,
  input  logic      cntRstN,
  output addr_ctl_t ctl
);

  // Priority: clear, then load, then step; otherwise hold.
  always_comb begin
    ctl.clear = ~cntRstN;
    ctl.load  = cntRstN & ~adsN;
    ctl.step  = cntRstN & adsN & ~cntEnN;
  end

endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  addr_ctl_t         ctl,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrQ
);

  localparam logic [ADDR_W-1:0] ZERO = '0;
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    addrNext = addrQ;
    if (ctl.clear)     addrNext = ZERO;
    else if (ctl.load) addrNext = extAddr;
    else if (ctl.step) addrNext = addrQ + ONE;
  end

  // No reset: contents are defined by the first clear or load.
  always_ff @(posedge clk) begin
    addrQ <= addrNext;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              adsN,
  input  logic              cntEnN,
  input  logic              cntRstN,
  output logic [ADDR_W-1:0] intAddr
);

  addr_ctl_t ctl;

  burst_addr_ctrl u_ctrl (
    .adsN    (adsN),
    .cntEnN  (cntEnN),
    .cntRstN (cntRstN),
    .ctl     (ctl)
  );

  burst_addr_path #(.ADDR_W(ADDR_W)) u_path (
    .clk     (clk),
    .ctl     (ctl),
    .extAddr (extAddr),
    .addrQ   (intAddr)
  );

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic [ADDR_W-1:0] extAddr,
  input logic              adsN,
  input logic              cntEnN,
  input logic              cntRstN,
  input logic [ADDR_W-1:0] intAddr
);

  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ALL1 = '1;

  // Set once the stored address has been defined by a clear or load.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (!cntRstN || !adsN) primed <= 1'b1;
  end

  // R1: strobe loads the external address
  a_r1_load: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && !adsN) |=> (intAddr == $past(extAddr)));

  // R2: count enable adds one
  a_r2_step: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && adsN && !cntEnN) |=> (intAddr == $past(intAddr) + ONE));

  // R3: idle inputs hold the address
  a_r3_hold: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && adsN && cntEnN) |=> $stable(intAddr));

  // R4: clear forces zero
  a_r4_clear: assert property (@(posedge clk) disable iff (!primed)
    (!cntRstN) |=> (intAddr == '0));

  // R6: all-ones wraps to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!primed)
    (cntRstN && adsN && !cntEnN && intAddr == ALL1) |=> (intAddr == '0));

endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .extAddr (extAddr),
  .adsN    (adsN),
  .cntEnN  (cntEnN),
  .cntRstN (cntRstN),
  .intAddr (intAddr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 15;
  localparam int NV = 15;

  typedef struct packed {
    logic          rstN;
    logic          adsN;
    logic          enN;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  // rstN, adsN, enN, ext, expected, requirement number
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 15'h1234, 15'h0000, 4'd4},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0001, 4'd5},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0002, 4'd2},
    '{1'b1, 1'b1, 1'b1, 15'h0000, 15'h0002, 4'd3},
    '{1'b1, 1'b1, 1'b1, 15'h7777, 15'h0002, 4'd3},
    '{1'b1, 1'b0, 1'b1, 15'h0100, 15'h0100, 4'd1},
    '{1'b1, 1'b0, 1'b0, 15'h0200, 15'h0200, 4'd7},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0201, 4'd2},
    '{1'b0, 1'b0, 1'b0, 15'h5555, 15'h0000, 4'd4},
    '{1'b1, 1'b0, 1'b1, 15'h7FFE, 15'h7FFE, 4'd1},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h7FFF, 4'd2},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0000, 4'd6},
    '{1'b1, 1'b1, 1'b0, 15'h0000, 15'h0001, 4'd6},
    '{1'b0, 1'b1, 1'b0, 15'h0000, 15'h0000, 4'd4},
    '{1'b1, 1'b1, 1'b1, 15'h0000, 15'h0000, 4'd3}
  };

  logic          clk = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          adsN = 1'b1;
  logic          cntEnN = 1'b1;
  logic          cntRstN = 1'b1;
  logic [AW-1:0] intAddr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk     (clk),
    .extAddr (extAddr),
    .adsN    (adsN),
    .cntEnN  (cntEnN),
    .cntRstN (cntRstN),
    .intAddr (intAddr)
  );

  // Drive at the falling edge, clock once, sample 1 ns after the rising edge.
  task automatic stepOnce(input logic r, input logic a, input logic e,
                          input logic [AW-1:0] x);
    @(negedge clk);
    cntRstN = r; adsN = a; cntEnN = e; extAddr = x;
    @(posedge clk);
    #1;
  endtask

  task automatic checkAddr(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (intAddr !== exp) begin
      fails++;
      $display("FAIL %s: intAddr=%h expected=%h", tag, intAddr, exp);
    end
  endtask

  initial begin
    // Table walk
    for (int i = 0; i < NV; i++) begin
      stepOnce(VECS[i].rstN, VECS[i].adsN, VECS[i].enN, VECS[i].ext);
      checkAddr(VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R2/R6 long burst across the top of the range
    stepOnce(1'b1, 1'b0, 1'b1, 15'h7FF0);
    checkAddr(15'h7FF0, "R1 burst start");
    for (int k = 1; k <= 40; k++) begin
      stepOnce(1'b1, 1'b1, 1'b0, 15'h0ABC);
      checkAddr(AW'(32'h7FF0 + k), "R2 R6 burst");
    end

    // R3 hold over several cycles while the external address changes
    for (int k = 0; k < 5; k++) begin
      stepOnce(1'b1, 1'b1, 1'b1, AW'(k * 1111));
      checkAddr(15'h0018, "R3 hold");
    end

    // R5 clear then immediate increments
    stepOnce(1'b0, 1'b0, 1'b1, 15'h2222);
    checkAddr(15'h0000, "R4 clear over load");
    stepOnce(1'b1, 1'b1, 1'b0, 15'h2222);
    checkAddr(15'h0001, "R5 step after clear");
    stepOnce(1'b1, 1'b1, 1'b0, 15'h2222);
    checkAddr(15'h0002, "R5 second step");

    // R7 load with enable low, then step
    stepOnce(1'b1, 1'b0, 1'b0, 15'h7FFF);
    checkAddr(15'h7FFF, "R7 load wins");
    stepOnce(1'b1, 1'b1, 1'b0, 15'h0000);
    checkAddr(15'h0000, "R6 wrap after load");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule